// File: doc/BRIEF.md
# GPIO Bank Controller with Peripheral Function Mux

This block controls one bank of general-purpose pins. Each pin is owned either by the GPIO logic or by one of four peripheral functions (A, B, C, D). Software changes per-pin state through paired registers: writing 1s to a "set" word turns the corresponding bits on, and writing 1s to a "clear" word turns them off. Bits written as 0 are left alone. A status word beside each pair reads back the current state. The controls covered are pin ownership, output direction, output data, open-drain, pull-up and pull-down.

The peripheral function of a pin is chosen by two select planes. Each plane is a directly written word that holds one bit per pin. The pad side of the block carries per-pin output-enable, output value and pull requests toward a pad model. The pad level is sampled every clock and can be read through the bus whatever the pin's owner. Each peripheral function receives the pad level on exactly the pins routed to it. Bus reads are combinational on the address, so a status read in the cycle after a write already shows the new value.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin ownership. A 1 written to OWN_SET (address 0) gives that pin to GPIO, and a 1 written to OWN_CLR (address 1) gives it to a peripheral. OWN_STAT (address 2) reads 1 for GPIO-owned pins.
- R2: Output direction. DIR_SET (3) enables driving on the masked pins and DIR_CLR (4) disables it. DIR_STAT (5) reads the state back. Pins whose mask bit is 0 keep their previous state.
- R3: Output data. DAT_SET (6) sets the output level of the masked pins to 1 and DAT_CLR (7) clears it to 0. DAT_STAT (8) reads the levels back.
- R4: PAD_LEVEL (address 20) returns the pad input level as registered at the last clock edge. This holds for every pin, whether GPIO or a peripheral owns it.
- R5: Open-drain. OD_SET (9) and OD_CLR (10) control it, and OD_STAT (11) reads it back. An open-drain pin never drives a high level. When its output value is 1 its output-enable is 0, and when the value is 0 it drives low.
- R6: Pulls. PU_SET (12), PU_CLR (13) and PU_STAT (14) control the pull-up. PD_SET (15), PD_CLR (16) and PD_STAT (17) control the pull-down. Enabling one pull on a pin clears the other pull on that pin, so both are never on together. The pad_pu and pad_pd outputs follow the status words.
- R7: Select planes. SEL_P1 (18) and SEL_P2 (19) are written directly and read back as written. A pin's function code is {P2 bit, P1 bit}: 00 selects A (index 0), 01 selects B (1), 10 selects C (2) and 11 selects D (3).
- R8: On a peripheral-owned pin, pad_oe and pad_out come from the selected function's periph_oe and periph_out bits, subject to open-drain. On a GPIO-owned pin they come from DIR and DAT. periph_in[f] carries the pad level only on pins that peripherals own and that select f. Every other bit of periph_in[f] is 0.
- R9: After reset, every pin is owned by GPIO, output driving is off, output data is 0, open-drain is off, pull-ups are on, pull-downs are off and both select planes are 0.
- R10: A write takes effect at the next clock edge. Writes to status addresses, PAD_LEVEL or unmapped addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Register address, used for both write and read |
| bus_wdata | input | NPINS | Write data or pin mask |
| bus_rdata | output | NPINS | Read data of the addressed register (combinational) |
| pad_in | input | NPINS | Level seen at each pad |
| pad_oe | output | NPINS | Per-pin output enable toward the pad |
| pad_out | output | NPINS | Per-pin output value toward the pad |
| pad_pu | output | NPINS | Per-pin pull-up request |
| pad_pd | output | NPINS | Per-pin pull-down request |
| periph_oe | input | 4 x NPINS | Output enable from each peripheral function |
| periph_out | input | 4 x NPINS | Output value from each peripheral function |
| periph_in | output | 4 x NPINS | Pad level routed to each peripheral function |

## Verification
The set/clear pairs are exercised with masks that overlap earlier writes, with masks that only partly cover them, and with an all-zero mask. Together these separate true set or clear behaviour from plain overwrite and from writes that wrongly touch unmasked bits. Pull writes go to pins that already have the opposite pull enabled, which shows whether the cross-clear is present. A mixed bank is then built: GPIO pins both driving and not driving, open-drain pins at 0 and at 1, and peripheral pins on all four select codes. In that bank each peripheral drives a different pattern, so any swap of the plane bits or any wrong function index shows up on pad_out and periph_in.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W   = 5;
    localparam int NUM_FUNC = 4;
    localparam int NUM_CTL  = 6;

    // control index: each control k occupies addresses 3k (set), 3k+1 (clear), 3k+2 (status)
    typedef enum int {
        CTL_OWN = 0,
        CTL_DIR = 1,
        CTL_DAT = 2,
        CTL_OD  = 3,
        CTL_PU  = 4,
        CTL_PD  = 5
    } ctl_idx_e;

    typedef enum logic [ADDR_W-1:0] {
        A_SEL_P1   = 5'd18,
        A_SEL_P2   = 5'd19,
        A_PAD_LVL  = 5'd20
    } dir_addr_e;

    typedef enum logic [1:0] {
        FN_A = 2'b00,
        FN_B = 2'b01,
        FN_C = 2'b10,
        FN_D = 2'b11
    } func_code_e;

    // reset state of a control word
    function automatic logic ctl_reset_bit(input int k);
        return (k == CTL_OWN) || (k == CTL_PU);
    endfunction

    function automatic logic [ADDR_W-1:0] ctl_addr(input int k, input int slot);
        return ADDR_W'(3 * k + slot);
    endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int   W       = 32,
    parameter logic RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] force_clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {W{RST_BIT}};
        end else begin
            q <= (q | set_mask) & ~clr_mask & ~force_clr;
        end
    end
endmodule

// File: rtl/gpio_sel_planes.sv
module gpio_sel_planes
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_p1,
    input  logic             wr_p2,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] plane1,
    output logic [NPINS-1:0] plane2,
    output func_code_e       code [NPINS]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            plane1 <= '0;
            plane2 <= '0;
        end else begin
            if (wr_p1) plane1 <= wdata;
            if (wr_p2) plane2 <= wdata;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_code
        assign code[i] = func_code_e'({plane2[i], plane1[i]});
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]                own,
    input  logic [NPINS-1:0]                dir,
    input  logic [NPINS-1:0]                dat,
    input  logic [NPINS-1:0]                od,
    input  func_code_e                      code [NPINS],
    input  logic [NUM_FUNC-1:0][NPINS-1:0]  periph_oe,
    input  logic [NUM_FUNC-1:0][NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]                pad_in,
    output logic [NPINS-1:0]                pad_oe,
    output logic [NPINS-1:0]                pad_out,
    output logic [NUM_FUNC-1:0][NPINS-1:0]  periph_in
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic raw_oe;
        logic raw_out;

        always_comb begin
            if (own[i]) begin
                raw_oe  = dir[i];
                raw_out = dat[i];
            end else begin
                raw_oe  = periph_oe[code[i]][i];
                raw_out = periph_out[code[i]][i];
            end
        end

        // open-drain: drive low only, release when high
        assign pad_oe[i]  = raw_oe & ~(od[i] & raw_out);
        assign pad_out[i] = raw_out & ~od[i];

        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
            assign periph_in[f][i] = (!own[i] && (int'(code[i]) == f)) ? pad_in[i] : 1'b0;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wen,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NPINS-1:0]               bus_wdata,
    output logic [NPINS-1:0]               bus_rdata,
    input  logic [NPINS-1:0]               pad_in,
    output logic [NPINS-1:0]               pad_oe,
    output logic [NPINS-1:0]               pad_out,
    output logic [NPINS-1:0]               pad_pu,
    output logic [NPINS-1:0]               pad_pd,
    input  logic [NUM_FUNC-1:0][NPINS-1:0] periph_oe,
    input  logic [NUM_FUNC-1:0][NPINS-1:0] periph_out,
    output logic [NUM_FUNC-1:0][NPINS-1:0] periph_in
);
    logic [NPINS-1:0] set_m  [NUM_CTL];
    logic [NPINS-1:0] clr_m  [NUM_CTL];
    logic [NPINS-1:0] frc_m  [NUM_CTL];
    logic [NPINS-1:0] ctl_q  [NUM_CTL];

    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        localparam logic [ADDR_W-1:0] A_SET = ctl_addr(k, 0);
        localparam logic [ADDR_W-1:0] A_CLR = ctl_addr(k, 1);

        assign set_m[k] = (bus_wen && bus_addr == A_SET) ? bus_wdata : '0;
        assign clr_m[k] = (bus_wen && bus_addr == A_CLR) ? bus_wdata : '0;

        gpio_setclr_reg #(
            .W       (NPINS),
            .RST_BIT (ctl_reset_bit(k))
        ) u_reg (
            .clk       (clk),
            .rst       (rst),
            .set_mask  (set_m[k]),
            .clr_mask  (clr_m[k]),
            .force_clr (frc_m[k]),
            .q         (ctl_q[k])
        );
    end

    // pulls are mutually exclusive: enabling one clears the other
    always_comb begin
        for (int k = 0; k < NUM_CTL; k++) frc_m[k] = '0;
        frc_m[CTL_PU] = set_m[CTL_PD];
        frc_m[CTL_PD] = set_m[CTL_PU];
    end

    logic [NPINS-1:0] own_q, dir_q, dat_q, od_q, pu_q, pd_q;
    assign own_q = ctl_q[CTL_OWN];
    assign dir_q = ctl_q[CTL_DIR];
    assign dat_q = ctl_q[CTL_DAT];
    assign od_q  = ctl_q[CTL_OD];
    assign pu_q  = ctl_q[CTL_PU];
    assign pd_q  = ctl_q[CTL_PD];

    logic [NPINS-1:0] plane1_q, plane2_q;
    func_code_e       pin_code [NPINS];

    gpio_sel_planes #(.NPINS(NPINS)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_p1  (bus_wen && bus_addr == A_SEL_P1),
        .wr_p2  (bus_wen && bus_addr == A_SEL_P2),
        .wdata  (bus_wdata),
        .plane1 (plane1_q),
        .plane2 (plane2_q),
        .code   (pin_code)
    );

    logic [NPINS-1:0] pad_lvl_q;
    always_ff @(posedge clk) begin
        if (rst) pad_lvl_q <= '0;
        else     pad_lvl_q <= pad_in;
    end

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .own        (own_q),
        .dir        (dir_q),
        .dat        (dat_q),
        .od         (od_q),
        .code       (pin_code),
        .periph_oe  (periph_oe),
        .periph_out (periph_out),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .periph_in  (periph_in)
    );

    assign pad_pu = pu_q;
    assign pad_pd = pd_q;

    // read mux: status of control k sits at 3k+2
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CTL; k++) begin
            if (bus_addr == ctl_addr(k, 2)) bus_rdata = ctl_q[k];
        end
        if (bus_addr == A_SEL_P1)  bus_rdata = plane1_q;
        if (bus_addr == A_SEL_P2)  bus_rdata = plane2_q;
        if (bus_addr == A_PAD_LVL) bus_rdata = pad_lvl_q;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wen,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NPINS-1:0]    bus_wdata,
    input logic [NPINS-1:0]    pad_in,
    input logic [NPINS-1:0]    pad_oe,
    input logic [NPINS-1:0]    pad_out,
    input logic [NPINS-1:0]    pad_pu,
    input logic [NPINS-1:0]    pad_pd,
    input logic [NPINS-1:0]    own_q,
    input logic [NPINS-1:0]    dir_q,
    input logic [NPINS-1:0]    dat_q,
    input logic [NPINS-1:0]    od_q,
    input logic [NPINS-1:0]    pad_lvl_q
);
    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);  // R6

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & od_q) == '0 && (pad_oe & od_q & ~pad_out) == (pad_oe & od_q));  // R5

    AST_OWN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == ADDR_W'(0)) |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata)));  // R1

    AST_OWN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == ADDR_W'(1)) |=> ((own_q & $past(bus_wdata)) == '0));  // R1

    AST_DIR_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == ADDR_W'(4)) |=>
            ((dir_q & $past(bus_wdata)) == '0) &&
            ((dir_q & ~$past(bus_wdata)) == ($past(dir_q) & ~$past(bus_wdata))));  // R2

    AST_DAT_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == ADDR_W'(6)) |=> ((dat_q & $past(bus_wdata)) == $past(bus_wdata)));  // R3

    AST_PAD_SAMPLED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pad_lvl_q == $past(pad_in));  // R4

    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == ADDR_W'(5)) |=> $stable(dir_q));  // R10
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .own_q     (own_q),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .od_q      (od_q),
    .pad_lvl_q (pad_lvl_q)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
    localparam int NP = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wen = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [NP-1:0]     bus_wdata = '0;
    logic [NP-1:0]     bus_rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [NP-1:0]     pad_oe, pad_out, pad_pu, pad_pd;
    logic [3:0][NP-1:0] periph_oe = '0;
    logic [3:0][NP-1:0] periph_out = '0;
    logic [3:0][NP-1:0] periph_in;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_bank_ctrl #(.NPINS(NP)) dut_i (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .periph_oe(periph_oe), .periph_out(periph_out), .periph_in(periph_in)
    );

    typedef struct packed {
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  32'h0000_00FF, 5'd5,  32'h0000_00FF, 8'd2},   // R2 set direction
        '{5'd4,  32'h0000_000F, 5'd5,  32'h0000_00F0, 8'd2},   // R2 clear part
        '{5'd6,  32'h0000_00A5, 5'd8,  32'h0000_00A5, 8'd3},   // R3 set data
        '{5'd7,  32'h0000_0005, 5'd8,  32'h0000_00A0, 8'd3},   // R3 clear data
        '{5'd1,  32'hFF00_0000, 5'd2,  32'h00FF_FFFF, 8'd1},   // R1 hand to peripheral
        '{5'd0,  32'h0100_0000, 5'd2,  32'h01FF_FFFF, 8'd1},   // R1 back to GPIO
        '{5'd15, 32'h0000_0003, 5'd14, 32'hFFFF_FFFC, 8'd6},   // R6 pd clears pu
        '{5'd12, 32'h0000_0001, 5'd17, 32'h0000_0002, 8'd6},   // R6 pu clears pd
        '{5'd16, 32'h0000_0002, 5'd17, 32'h0000_0000, 8'd6},   // R6 pd clear
        '{5'd9,  32'h0000_0030, 5'd11, 32'h0000_0030, 8'd5},   // R5 open-drain set
        '{5'd18, 32'h0A00_0000, 5'd18, 32'h0A00_0000, 8'd7},   // R7 plane 1
        '{5'd19, 32'h0C00_0000, 5'd19, 32'h0C00_0000, 8'd7},   // R7 plane 2
        '{5'd3,  32'h0000_0000, 5'd5,  32'h0000_00F0, 8'd2},   // R2 zero mask
        '{5'd5,  32'hFFFF_FFFF, 5'd5,  32'h0000_00F0, 8'd10}   // R10 status write inert
    };

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [NP-1:0] v;
        do_reset();

        // R9 reset state
        rd(5'd2, v);  chk("R9 own", v, 32'hFFFF_FFFF);
        rd(5'd5, v);  chk("R9 dir", v, 32'h0);
        rd(5'd14, v); chk("R9 pullup", v, 32'hFFFF_FFFF);
        rd(5'd17, v); chk("R9 pulldown", v, 32'h0);
        rd(5'd18, v); chk("R9 plane1", v, 32'h0);
        #1 chk("R9 pad_oe", pad_oe, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].ex);
        end

        // R10 unmapped read
        rd(5'd30, v); chk("R10 unmapped read", v, 32'h0);

        // R6 pull outputs follow status
        #1;
        chk("R6 pad_pu", pad_pu, 32'hFFFF_FFFD);
        chk("R6 pad_pd", pad_pd, 32'h0);

        // R5/R2/R3 pad drive with peripherals idle
        chk("R5 pad_oe gpio", pad_oe, 32'h0000_00D0);
        chk("R5 pad_out gpio", pad_out, 32'h0000_0080);

        // R8 peripheral routing: A=0, B=1s, C=0, D=1s, all enabling
        periph_oe  = {4{32'hFFFF_FFFF}};
        periph_out = {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0};
        pad_in     = 32'hFFFF_FFFF;
        #1;
        chk("R8 pad_oe mixed", pad_oe, 32'hFE00_00D0);
        chk("R8 pad_out mixed", pad_out, 32'h0A00_0080);
        chk("R8 periph_in A", periph_in[0], 32'hF000_0000);
        chk("R8 periph_in B", periph_in[1], 32'h0200_0000);
        chk("R8 periph_in C", periph_in[2], 32'h0400_0000);
        chk("R8 periph_in D", periph_in[3], 32'h0800_0000);

        // R4 pad level on GPIO and peripheral pins
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        rd(5'd20, v); chk("R4 pad level", v, 32'h1234_5678);

        // R10 write to PAD_LEVEL ignored
        wr(5'd20, 32'h0);
        rd(5'd20, v); chk("R10 pad level write inert", v, 32'h1234_5678);

        // R9 reset again clears everything
        do_reset();
        rd(5'd8, v);  chk("R9 data after reset", v, 32'h0);
        rd(5'd19, v); chk("R9 plane2 after reset", v, 32'h0);
        rd(5'd11, v); chk("R9 od after reset", v, 32'h0);
        #1 chk("R9 pad_oe after reset", pad_oe, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule